// File: doc/BRIEF.md
# Coprocessor Instruction Stream Follower

This block lets a coprocessor follow a host processor's instruction stream without ever driving the bus. It snoops the host's code fetches into a shadow copy of the host's prefetch queue. The host's two queue-status pins tell it when a byte is taken from the queue and when the queue is thrown away. From the taken bytes it picks out the escape instructions meant for the coprocessor. For each one it latches the 3 opcode bits of the escape byte and the whole ModR/M byte.

When the ModR/M byte names a memory operand, the host works out the effective address itself and issues one dummy read there. The block skips the displacement bytes that follow ModR/M and captures the address of that read. The coprocessor can then reuse the host's address arithmetic. A one-cycle valid strobe presents the 11-bit opcode, the captured 20-bit address and a flag that says whether an address was captured.

Top module: `cop_snoop_tracker`

## Requirements
- R1: A byte taken with queue status 01 starts a coprocessor instruction only when its bits [7:3] equal 11011. Its bits [2:0] are latched as opcode bits [10:8].
- R2: The byte taken next with status 11 is the ModR/M byte and becomes opcode bits [7:0]. opcode_o = {escape[2:0], modrm[7:0]}.
- R3: host_narrow_i is sampled on the first clock edge after reset is released. When it is 1 (8-bit host), each fetch_i pushes one byte, fetch_data_i[7:0], into a 4-byte shadow queue. When it is 0 (16-bit host), each fetch_i pushes two bytes, fetch_data_i[7:0] first and then fetch_data_i[15:8], into a 6-byte shadow queue.
- R4: The queue-status codes are: 00 takes nothing, 01 takes the first byte of an instruction, 11 takes a subsequent byte, and 10 discards every queued byte.
- R5: When ModR/M bits [7:6] are 11, valid_o pulses in the cycle after the ModR/M byte is taken, with mem_o = 0. No bus read is awaited.
- R6: In a memory form, the bytes that follow ModR/M are skipped as displacement and are never decoded. The count is 1 for mode 01, 2 for mode 10, 2 for mode 00 with R/M = 110, and 0 for every other mode-00 case. Host reads issued before the last displacement byte is taken are ignored.
- R7: In a memory form, the first rd_i after the displacement has been consumed is captured. valid_o pulses in the next cycle with mem_o = 1 and addr_o equal to that read's rd_addr_i.
- R8: valid_o is high for exactly one cycle per tracked instruction. Host reads with no memory-form instruction pending produce no strobe. Reset clears valid_o and mem_o.
- R9: A flush (status 10) in the middle of an instruction abandons it with no strobe. Bytes queued before the flush are never decoded.
- R10: Bytes of a non-escape instruction, including subsequent bytes that look like escape bytes, produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_narrow_i | input | 1 | Strap: 1 = host with an 8-bit bus, 0 = host with a 16-bit bus |
| qs_i | input | 2 | Host queue status (00 none, 01 first byte, 10 flush, 11 next byte) |
| fetch_i | input | 1 | Host code fetch completes this cycle |
| fetch_data_i | input | 16 | Data of the code fetch |
| rd_i | input | 1 | Host data read completes this cycle |
| rd_addr_i | input | 20 | Address of that read |
| valid_o | output | 1 | One-cycle strobe for a tracked coprocessor instruction |
| opcode_o | output | 11 | Escape bits followed by the ModR/M byte |
| mem_o | output | 1 | An operand address was captured |
| addr_o | output | 20 | Captured operand address |

## Verification
Each displacement length is paired with a decoy read issued before the last displacement byte is taken. A follower that counts the displacement wrongly would capture the decoy, or would hang waiting for a read. A flush arrives while stale bytes are still queued, so a queue that kept them would hand out the wrong ModR/M byte. In 8-bit mode the upper data byte carries an escape pattern, so a follower that pushed both bytes would decode phantom instructions. A non-escape instruction whose second byte looks like an escape byte, and reads with nothing pending, would show up as stray strobes.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    QS_NONE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qs_e;

  typedef enum logic [1:0] {
    TR_IDLE, TR_MODRM, TR_DISP, TR_WAIT_RD
  } trk_e;

  localparam logic [4:0] ESC_TAG = 5'b11011;
  localparam int OPC_W = 11;

  function automatic logic [1:0] disp_len(input logic [7:0] modrm);
    case (modrm[7:6])
      2'b00:   disp_len = (modrm[2:0] == 3'b110) ? 2'd2 : 2'd0;
      2'b01:   disp_len = 2'd1;
      2'b10:   disp_len = 2'd2;
      default: disp_len = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/snoop_queue.sv
module snoop_queue #(
  parameter int DEPTH_WIDE   = 6,
  parameter int DEPTH_NARROW = 4,
  localparam int PW = $clog2(DEPTH_WIDE),
  localparam int CW = $clog2(DEPTH_WIDE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          narrow_i,
  input  logic          push_i,
  input  logic [15:0]   push_data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [7:0]    head_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o
);
  logic [DEPTH_WIDE-1:0][7:0] slots_q;
  logic [PW-1:0] rd_q, wr_q, rd_base, wr_base, wr_plus1, last;
  logic [CW-1:0] cnt_q, cnt_base, cnt_d;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [PW-1:0] lim);
    return (p == lim) ? '0 : p + 1'b1;
  endfunction

  assign last = narrow_i ? PW'(DEPTH_NARROW - 1) : PW'(DEPTH_WIDE - 1);

  always_comb begin
    rd_base  = flush_i ? '0 : (pop_i ? step(rd_q, last) : rd_q);
    wr_base  = flush_i ? '0 : wr_q;
    wr_plus1 = step(wr_base, last);
    cnt_base = flush_i ? '0 : cnt_q - CW'(pop_i);
    cnt_d    = cnt_base + (push_i ? (narrow_i ? CW'(1) : CW'(2)) : CW'(0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
      slots_q <= '0;
    end else begin
      rd_q  <= rd_base;
      cnt_q <= cnt_d;
      if (push_i) wr_q <= narrow_i ? wr_plus1 : step(wr_plus1, last);
      else        wr_q <= wr_base;
      for (int i = 0; i < DEPTH_WIDE; i++) begin
        if (push_i && wr_base == PW'(i))
          slots_q[i] <= push_data_i[7:0];
        else if (push_i && !narrow_i && wr_plus1 == PW'(i))
          slots_q[i] <= push_data_i[15:8];
      end
    end
  end

  assign head_o  = slots_q[rd_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/esc_follower.sv
module esc_follower
  import cst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] qs_i,
  input  logic [7:0] head_i,
  input  logic       rd_i,
  output logic       capture_o,
  output logic       valid_o,
  output logic       mem_o,
  output logic [OPC_W-1:0] opcode_o
);
  trk_e        st_q, st_d;
  logic [2:0]  esc_q, esc_d;
  logic [7:0]  modrm_q, modrm_d;
  logic [1:0]  left_q, left_d;
  logic        valid_d, mem_q, mem_d;
  logic [1:0]  dl;

  assign dl = disp_len(head_i);

  always_comb begin
    st_d    = st_q;
    esc_d   = esc_q;
    modrm_d = modrm_q;
    left_d  = left_q;
    valid_d = 1'b0;
    mem_d   = mem_q;
    capture_o = (st_q == TR_WAIT_RD) && rd_i;
    if (capture_o) begin
      valid_d = 1'b1;
      mem_d   = 1'b1;
      st_d    = TR_IDLE;
    end
    case (qs_e'(qs_i))
      QS_FLUSH: st_d = TR_IDLE;
      QS_FIRST: begin
        if (head_i[7:3] == ESC_TAG) begin
          esc_d = head_i[2:0];
          st_d  = TR_MODRM;
        end else begin
          st_d = TR_IDLE;
        end
      end
      QS_NEXT: begin
        case (st_q)
          TR_MODRM: begin
            modrm_d = head_i;
            if (head_i[7:6] == 2'b11) begin
              valid_d = 1'b1;
              mem_d   = 1'b0;
              st_d    = TR_IDLE;
            end else if (dl == 2'd0) begin
              st_d = TR_WAIT_RD;
            end else begin
              left_d = dl;
              st_d   = TR_DISP;
            end
          end
          TR_DISP: begin
            left_d = left_q - 2'd1;
            if (left_q == 2'd1) st_d = TR_WAIT_RD;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= TR_IDLE;
      esc_q   <= '0;
      modrm_q <= '0;
      left_q  <= '0;
      valid_o <= 1'b0;
      mem_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      esc_q   <= esc_d;
      modrm_q <= modrm_d;
      left_q  <= left_d;
      valid_o <= valid_d;
      mem_q   <= mem_d;
    end
  end

  assign mem_o    = mem_q;
  assign opcode_o = {esc_q, modrm_q};
endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int ADDR_W = 20,
  parameter int SEG_W  = 10,
  localparam int NSEG  = ADDR_W / SEG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W-1:0] seg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    seg_q <= '0;
      else if (cap_i) seg_q <= addr_i[g*SEG_W +: SEG_W];
    end
    assign addr_o[g*SEG_W +: SEG_W] = seg_q;
  end
endmodule

// File: rtl/cop_snoop_tracker.sv
module cop_snoop_tracker
  import cst_pkg::*;
#(
  parameter int DEPTH_WIDE   = 6,
  parameter int DEPTH_NARROW = 4,
  parameter int ADDR_W       = 20,
  parameter int SEG_W        = 10,
  localparam int CW = $clog2(DEPTH_WIDE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_narrow_i,
  input  logic [1:0]        qs_i,
  input  logic              fetch_i,
  input  logic [15:0]       fetch_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              valid_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic              mem_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic          narrow_q, strap_done_q;
  logic [7:0]    q_head;
  logic [CW-1:0] q_count;
  logic          q_empty, q_pop, q_flush, capture;

  // strap taken once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      narrow_q     <= 1'b0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      narrow_q     <= host_narrow_i;
      strap_done_q <= 1'b1;
    end
  end

  assign q_pop   = (qs_i == QS_FIRST) || (qs_i == QS_NEXT);
  assign q_flush = (qs_i == QS_FLUSH);

  snoop_queue #(.DEPTH_WIDE(DEPTH_WIDE), .DEPTH_NARROW(DEPTH_NARROW)) u_queue (
    .clk_i, .rst_ni,
    .narrow_i    (narrow_q),
    .push_i      (fetch_i),
    .push_data_i (fetch_data_i),
    .pop_i       (q_pop),
    .flush_i     (q_flush),
    .head_o      (q_head),
    .count_o     (q_count),
    .empty_o     (q_empty)
  );

  esc_follower u_follow (
    .clk_i, .rst_ni,
    .qs_i,
    .head_i    (q_head),
    .rd_i,
    .capture_o (capture),
    .valid_o,
    .mem_o,
    .opcode_o
  );

  addr_latch #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_addr (
    .clk_i, .rst_ni,
    .cap_i  (capture),
    .addr_i (rd_addr_i),
    .addr_o
  );
endmodule

// File: rtl/cst_checker.sv
module cst_checker #(
  parameter int DEPTH_WIDE   = 6,
  parameter int DEPTH_NARROW = 4,
  parameter int ADDR_W       = 20,
  parameter int CW           = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        qs_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              valid_o,
  input logic [10:0]       opcode_o,
  input logic              mem_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CW-1:0]     q_count,
  input logic              q_empty,
  input logic              q_narrow
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
  AST_REG_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && opcode_o[7:6] == 2'b11 |-> !mem_o); // R5
  AST_MEM_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && opcode_o[7:6] != 2'b11 |-> mem_o && $past(rd_i)); // R7
  AST_ADDR_FROM_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && mem_o |-> addr_o == $past(rd_addr_i)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= (q_narrow ? CW'(DEPTH_NARROW) : CW'(DEPTH_WIDE))); // R3
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qs_i == 2'b01 || qs_i == 2'b11) |-> !q_empty); // R4
endmodule

bind cop_snoop_tracker cst_checker #(
  .DEPTH_WIDE(DEPTH_WIDE), .DEPTH_NARROW(DEPTH_NARROW), .ADDR_W(ADDR_W), .CW(CW)
) u_chk (
  .clk_i, .rst_ni, .qs_i, .rd_i, .rd_addr_i, .valid_o, .opcode_o, .mem_o, .addr_o,
  .q_count(q_count), .q_empty(q_empty), .q_narrow(narrow_q)
);

// File: tb/cop_snoop_tracker_test.sv
module cop_snoop_tracker_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_narrow_i = 1'b0;
  logic [1:0]  qs_i = 2'b00;
  logic        fetch_i = 1'b0;
  logic [15:0] fetch_data_i = '0;
  logic        rd_i = 1'b0;
  logic [19:0] rd_addr_i = '0;
  logic        valid_o, mem_o;
  logic [10:0] opcode_o;
  logic [19:0] addr_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] sb[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  cop_snoop_tracker uut (
    .clk_i(clk), .rst_ni, .host_narrow_i, .qs_i, .fetch_i, .fetch_data_i,
    .rd_i, .rd_addr_i, .valid_o, .opcode_o, .mem_o, .addr_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(input logic [1:0] qs, input logic f, input logic [15:0] d,
                     input logic r, input logic [19:0] a);
    qs_i = qs; fetch_i = f; fetch_data_i = d; rd_i = r; rd_addr_i = a;
    @(negedge clk);
  endtask

  task automatic idle();                    drv(2'b00, 0, '0, 0, '0); endtask
  task automatic fetch(input logic [15:0] d); drv(2'b00, 1, d, 0, '0); endtask
  task automatic pop_first();               drv(2'b01, 0, '0, 0, '0); endtask
  task automatic pop_next();                drv(2'b11, 0, '0, 0, '0); endtask
  task automatic flush();                   drv(2'b10, 0, '0, 0, '0); endtask
  task automatic rd(input logic [19:0] a);  drv(2'b00, 0, '0, 1, a); endtask
  task automatic expect_item(input logic [10:0] op, input logic m, input logic [19:0] a);
    sb.push_back({op, m, a});
  endtask

  // monitor: every strobe must match the oldest expected item
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        chk(0, "R8 unexpected strobe", {opcode_o, mem_o, addr_o}, '0);
      end else begin
        logic [31:0] e;
        e = sb.pop_front();
        chk(opcode_o == e[31:21], "R2 opcode", 32'(opcode_o), 32'(e[31:21]));
        chk(mem_o == e[20], "R5/R7 mem flag", 32'(mem_o), 32'(e[20]));
        if (e[20]) chk(addr_o == e[19:0], "R7 address", 32'(addr_o), 32'(e[19:0]));
      end
    end
  end

  task automatic do_reset(input logic narrow);
    rst_ni = 1'b0;
    host_narrow_i = narrow;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle();
    host_narrow_i = ~narrow; // strap must already be taken
  endtask

  task automatic finish_run();
    chk(sb.size() == 0, "R8 missing strobe", 32'(sb.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // 16-bit host
    do_reset(1'b0);
    chk(valid_o == 0 && mem_o == 0, "R8 reset state", {valid_o, mem_o}, 0);

    // R1 R2 R5: register form D9 E8
    fetch(16'hE8D9);
    pop_first();
    expect_item({3'b001, 8'hE8}, 0, '0);
    pop_next();
    chk(valid_o == 1, "R5 strobe after ModR/M", 32'(valid_o), 1);
    idle();
    chk(valid_o == 0, "R8 single-cycle strobe", 32'(valid_o), 0);

    // R6 R7: mode 01, one displacement byte, then a non-escape 90
    fetch(16'h45DC);
    fetch(16'h9012);
    pop_first();
    pop_next();
    rd(20'h11111); // decoy before displacement taken
    pop_next();
    chk(valid_o == 0, "R6 decoy ignored", 32'(valid_o), 0);
    expect_item({3'b100, 8'h45}, 1, 20'hABCDE);
    rd(20'hABCDE);
    chk(valid_o == 1, "R7 strobe after read", 32'(valid_o), 1);
    pop_first(); // 0x90, R10
    idle();

    // R6 mode 00 R/M 110: two displacement bytes, R4 idle gaps
    fetch(16'h06DD);
    fetch(16'h1234);
    pop_first();
    idle();
    pop_next();
    pop_next();
    rd(20'h22222); // decoy between displacement bytes
    idle();
    pop_next();
    expect_item({3'b101, 8'h06}, 1, 20'h12345);
    rd(20'h12345);
    chk(valid_o == 1, "R6 two-byte skip for R/M 110", 32'(valid_o), 1);
    idle();

    // R6 mode 10: two displacement bytes
    fetch(16'h87D8);
    fetch(16'h2211);
    pop_first();
    pop_next();
    pop_next();
    rd(20'h33333);
    pop_next();
    expect_item({3'b000, 8'h87}, 1, 20'h0F0F0);
    rd(20'h0F0F0);
    idle();

    // R6 mode 00 without displacement, all-ones address
    fetch(16'h07DF);
    pop_first();
    pop_next();
    chk(valid_o == 0, "R7 no strobe before read", 32'(valid_o), 0);
    expect_item({3'b111, 8'h07}, 1, 20'hFFFFF);
    rd(20'hFFFFF);
    chk(valid_o == 1 && addr_o == 20'hFFFFF, "R7 boundary address", 32'(addr_o), 32'hFFFFF);
    idle();

    // R10: non-escape 8B with escape-looking D8 byte, then stray read (R8)
    fetch(16'hD88B);
    pop_first();
    pop_next();
    rd(20'h44444);
    chk(valid_o == 0, "R10 non-escape ignored", 32'(valid_o), 0);

    // R9: flush mid-instruction with stale bytes queued
    fetch(16'h25DB);
    fetch(16'hBBAA);
    pop_first();
    flush();
    rd(20'h55555);
    chk(valid_o == 0, "R9 flush abandons", 32'(valid_o), 0);
    fetch(16'hC1D9);
    pop_first();
    expect_item({3'b001, 8'hC1}, 0, '0);
    pop_next();
    chk(valid_o == 1 && opcode_o == {3'b001, 8'hC1}, "R9 stale bytes dropped",
        32'(opcode_o), 32'({3'b001, 8'hC1}));
    idle();

    // R3: 8-bit host, upper data byte carries escape-like junk
    do_reset(1'b1);
    chk(valid_o == 0, "R8 reset state narrow", 32'(valid_o), 0);
    fetch(16'hDBD9);
    fetch(16'hDBF0);
    pop_first();
    expect_item({3'b001, 8'hF0}, 0, '0);
    pop_next();
    chk(valid_o == 1, "R3 one byte per fetch", 32'(valid_o), 1);
    fetch(16'hD8DA);
    fetch(16'hD886);
    fetch(16'hD801);
    fetch(16'hD802);
    pop_first();
    pop_next();
    pop_next();
    pop_next();
    expect_item({3'b010, 8'h86}, 1, 20'h54321);
    rd(20'h54321);
    chk(valid_o == 1, "R3 narrow wrap and capture", 32'(valid_o), 1);
    fetch(16'hDDD9);
    fetch(16'hDDE1);
    pop_first();
    expect_item({3'b001, 8'hE1}, 0, '0);
    pop_next();
    idle();
    idle();

    finish_run();
  end
endmodule